// File: doc/BRIEF.md
# Frame Statistics Event Classifier

This block sits between a network MAC's transmit and receive completion logic and a bank of statistics counters. Each time a frame finishes, the block takes that frame's completion status and sorts it into increment strobes, one per statistic. It also produces the octet amount to add to each direction's byte total. The counters and any host access to them live elsewhere. The block only decides which counters advance in a given cycle and by how much the octet totals grow.

On transmit the block looks at:
- the success or excessive-collision abort status;
- the collision count of the frame;
- the deferral flags;
- the carrier-loss flag;
- the destination address;
- the frame length.

A separate strobe reports each late collision as it happens. On receive the block looks at the success status, the destination address, the length and a receive FIFO overrun flag. All outputs are registered, so they appear in the clock cycle after the completion pulse.

Top module: `stat_evt_classifier`

## Requirements
- R1: While `rst_ni` is low, every bit of `stat_inc_o` and both octet outputs are zero. A completion sampled at a rising edge shows on the outputs after that edge, and the outputs return to zero in a cycle with no event. The bit order of `stat_inc_o` is:
  - 0: transmit OK
  - 1: transmit broadcast OK
  - 2: transmit multicast OK
  - 3: deferred
  - 4: excessive deferral
  - 5: single collision
  - 6: multiple collision
  - 7: late collision
  - 8: excessive-collision abort
  - 9: carrier-sense error
  - 10: receive OK
  - 11: receive broadcast OK
  - 12: receive multicast OK
  - 13: receive lost to overrun
- R2: Bit 0 is set for every transmit completion with `tx_ok_i` high, including frames that lost carrier. `tx_octets_o` equals `tx_len_i` for such a frame and is zero otherwise.
- R3: A destination address of all ones is broadcast. Any other address with bit 40 set (the group bit of the first octet, which is held in bits 47:40) is multicast. Broadcast and multicast OK bits (1, 2, 11, 12) are set only for error-free frames of that type.
- R4: Bit 5 is set only for an OK transmit frame whose collision count is exactly 1.
- R5: Bit 6 is set only for an OK transmit frame whose collision count is from 2 to 15.
- R6: Bit 7 follows each late-collision occurrence strobe one cycle later, independently of frame completion. Several strobes for one frame give several increments.
- R7: Bit 8 is set for a transmit completion that was not OK and was aborted for excessive collisions.
- R8: Bit 9 is set for an OK transmit frame that lost carrier.
- R9: Bits 3 and 4 are set once per transmit completion whose deferred flag or excessive-deferral flag, respectively, is high, whatever the frame's status.
- R10: Bit 10 and `rx_octets_o` = `rx_len_i` are produced only for a receive completion that is OK and not overrun. Otherwise `rx_octets_o` is zero.
- R11: Bit 13 is set for a receive completion with `rx_overrun_i` high.
- R12: Frame status inputs are ignored when their completion strobe is low, and every frame-derived output then stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_done_i | input | 1 | Transmit completion pulse |
| tx_ok_i | input | 1 | Transmit frame sent without error |
| tx_xscol_abort_i | input | 1 | Transmit aborted for excessive collisions |
| tx_coll_cnt_i | input | COLL_W (5) | Collisions seen by the frame |
| tx_late_coll_i | input | 1 | One late collision occurred |
| tx_deferred_i | input | 1 | First attempt was deferred |
| tx_excess_defer_i | input | 1 | Deferral exceeded the limit |
| tx_carrier_lost_i | input | 1 | Carrier lost during transmission |
| tx_dest_i | input | ADDR_W (48) | Transmit destination address |
| tx_len_i | input | LEN_W (16) | Transmit frame length in octets |
| rx_done_i | input | 1 | Receive completion pulse |
| rx_ok_i | input | 1 | Receive frame without error |
| rx_overrun_i | input | 1 | Frame dropped by receive FIFO overrun |
| rx_dest_i | input | ADDR_W (48) | Receive destination address |
| rx_len_i | input | LEN_W (16) | Receive frame length in octets |
| stat_inc_o | output | 14 | Per-statistic increment strobes |
| tx_octets_o | output | LEN_W (16) | Transmit octet add value |
| rx_octets_o | output | LEN_W (16) | Receive octet add value |

## Verification
The assertions assume that the MAC never reports a transmit frame as both OK and aborted. They also assume that a receive frame flagged as overrun is never also flagged OK. Given those two conditions, strobes such as abort, carrier error and the collision bins can be related to the OK strobe and to past inputs. The driver only builds completions that honour both exclusions. It otherwise varies the collision count across the bin edges 0, 1, 2, 15 and 16, crosses the address types with good and failed frames, and sends late-collision strobes on cycles with and without a completion.

// File: rtl/stat_evt_pkg.sv
package stat_evt_pkg;
  localparam int TX_NUM    = 10;
  localparam int RX_NUM    = 4;
  localparam int NUM_STATS = TX_NUM + RX_NUM;
  // strobe positions (counter bank decodes these)
  localparam int S_TX_OK     = 0;
  localparam int S_TX_BC     = 1;
  localparam int S_TX_MC     = 2;
  localparam int S_TX_DEFER  = 3;
  localparam int S_TX_XDEFER = 4;
  localparam int S_TX_SCOL   = 5;
  localparam int S_TX_MCOL   = 6;
  localparam int S_TX_LATE   = 7;
  localparam int S_TX_XSCOL  = 8;
  localparam int S_TX_CRS    = 9;
  localparam int S_RX_OK     = 10;
  localparam int S_RX_BC     = 11;
  localparam int S_RX_MC     = 12;
  localparam int S_RX_LOST   = 13;

  typedef enum logic [1:0] {
    DST_UNICAST = 2'd0,
    DST_MULTI   = 2'd1,
    DST_BCAST   = 2'd2
  } dst_kind_e;
endpackage

// File: rtl/stat_addr_class.sv
module stat_addr_class
  import stat_evt_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dst_kind_e         kind_o
);
  localparam int GROUP_BIT = ADDR_W - 8;  // lsb of first octet

  always_comb begin
    if (&addr_i)                kind_o = DST_BCAST;
    else if (addr_i[GROUP_BIT]) kind_o = DST_MULTI;
    else                        kind_o = DST_UNICAST;
  end
endmodule

// File: rtl/stat_tx_class.sv
module stat_tx_class
  import stat_evt_pkg::*;
#(
  parameter int COLL_W   = 5,
  parameter int LEN_W    = 16,
  parameter int MAX_COLL = 15
) (
  input  logic              done_i,
  input  logic              ok_i,
  input  logic              xscol_abort_i,
  input  logic [COLL_W-1:0] coll_cnt_i,
  input  logic              late_coll_i,
  input  logic              deferred_i,
  input  logic              excess_defer_i,
  input  logic              carrier_lost_i,
  input  dst_kind_e         kind_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [TX_NUM-1:0] strb_o,
  output logic [LEN_W-1:0]  octets_o
);
  logic frame_ok, one_coll, many_coll;

  assign frame_ok  = done_i & ok_i;
  assign one_coll  = (int'(coll_cnt_i) == 1);
  assign many_coll = (int'(coll_cnt_i) >= 2) && (int'(coll_cnt_i) <= MAX_COLL);

  always_comb begin
    strb_o              = '0;
    strb_o[S_TX_OK]     = frame_ok;
    strb_o[S_TX_BC]     = frame_ok & (kind_i == DST_BCAST);
    strb_o[S_TX_MC]     = frame_ok & (kind_i == DST_MULTI);
    strb_o[S_TX_DEFER]  = done_i & deferred_i;
    strb_o[S_TX_XDEFER] = done_i & excess_defer_i;
    strb_o[S_TX_SCOL]   = frame_ok & one_coll;
    strb_o[S_TX_MCOL]   = frame_ok & many_coll;
    strb_o[S_TX_LATE]   = late_coll_i;  // per occurrence, not per frame
    strb_o[S_TX_XSCOL]  = done_i & ~ok_i & xscol_abort_i;
    strb_o[S_TX_CRS]    = frame_ok & carrier_lost_i;
    octets_o            = frame_ok ? len_i : '0;
  end
endmodule

// File: rtl/stat_rx_class.sv
module stat_rx_class
  import stat_evt_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              done_i,
  input  logic              ok_i,
  input  logic              overrun_i,
  input  dst_kind_e         kind_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [RX_NUM-1:0] strb_o,
  output logic [LEN_W-1:0]  octets_o
);
  logic frame_ok;
  assign frame_ok = done_i & ok_i & ~overrun_i;

  always_comb begin
    strb_o                     = '0;
    strb_o[S_RX_OK   - TX_NUM] = frame_ok;
    strb_o[S_RX_BC   - TX_NUM] = frame_ok & (kind_i == DST_BCAST);
    strb_o[S_RX_MC   - TX_NUM] = frame_ok & (kind_i == DST_MULTI);
    strb_o[S_RX_LOST - TX_NUM] = done_i & overrun_i;
    octets_o                   = frame_ok ? len_i : '0;
  end
endmodule

// File: rtl/stat_evt_classifier.sv
module stat_evt_classifier
  import stat_evt_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int COLL_W   = 5,
  parameter int LEN_W    = 16,
  parameter int MAX_COLL = 15
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tx_done_i,
  input  logic                 tx_ok_i,
  input  logic                 tx_xscol_abort_i,
  input  logic [COLL_W-1:0]    tx_coll_cnt_i,
  input  logic                 tx_late_coll_i,
  input  logic                 tx_deferred_i,
  input  logic                 tx_excess_defer_i,
  input  logic                 tx_carrier_lost_i,
  input  logic [ADDR_W-1:0]    tx_dest_i,
  input  logic [LEN_W-1:0]     tx_len_i,
  input  logic                 rx_done_i,
  input  logic                 rx_ok_i,
  input  logic                 rx_overrun_i,
  input  logic [ADDR_W-1:0]    rx_dest_i,
  input  logic [LEN_W-1:0]     rx_len_i,
  output logic [NUM_STATS-1:0] stat_inc_o,
  output logic [LEN_W-1:0]     tx_octets_o,
  output logic [LEN_W-1:0]     rx_octets_o
);
  dst_kind_e         tx_kind, rx_kind;
  logic [TX_NUM-1:0] tx_strb;
  logic [RX_NUM-1:0] rx_strb;
  logic [LEN_W-1:0]  tx_oct, rx_oct;

  stat_addr_class #(.ADDR_W(ADDR_W)) tx_addr_i (.addr_i(tx_dest_i), .kind_o(tx_kind));
  stat_addr_class #(.ADDR_W(ADDR_W)) rx_addr_i (.addr_i(rx_dest_i), .kind_o(rx_kind));

  stat_tx_class #(.COLL_W(COLL_W), .LEN_W(LEN_W), .MAX_COLL(MAX_COLL)) tx_cls_i (
    .done_i        (tx_done_i),
    .ok_i          (tx_ok_i),
    .xscol_abort_i (tx_xscol_abort_i),
    .coll_cnt_i    (tx_coll_cnt_i),
    .late_coll_i   (tx_late_coll_i),
    .deferred_i    (tx_deferred_i),
    .excess_defer_i(tx_excess_defer_i),
    .carrier_lost_i(tx_carrier_lost_i),
    .kind_i        (tx_kind),
    .len_i         (tx_len_i),
    .strb_o        (tx_strb),
    .octets_o      (tx_oct)
  );

  stat_rx_class #(.LEN_W(LEN_W)) rx_cls_i (
    .done_i   (rx_done_i),
    .ok_i     (rx_ok_i),
    .overrun_i(rx_overrun_i),
    .kind_i   (rx_kind),
    .len_i    (rx_len_i),
    .strb_o   (rx_strb),
    .octets_o (rx_oct)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_inc_o  <= '0;
      tx_octets_o <= '0;
      rx_octets_o <= '0;
    end else begin
      stat_inc_o  <= {rx_strb, tx_strb};
      tx_octets_o <= tx_oct;
      rx_octets_o <= rx_oct;
    end
  end
endmodule

// File: rtl/stat_evt_checker.sv
module stat_evt_checker
  import stat_evt_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int COLL_W   = 5,
  parameter int LEN_W    = 16,
  parameter int MAX_COLL = 15
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tx_done_i,
  input logic                 tx_ok_i,
  input logic                 tx_xscol_abort_i,
  input logic [COLL_W-1:0]    tx_coll_cnt_i,
  input logic                 tx_late_coll_i,
  input logic                 tx_deferred_i,
  input logic                 tx_excess_defer_i,
  input logic                 tx_carrier_lost_i,
  input logic [ADDR_W-1:0]    tx_dest_i,
  input logic [LEN_W-1:0]     tx_len_i,
  input logic                 rx_done_i,
  input logic                 rx_ok_i,
  input logic                 rx_overrun_i,
  input logic [ADDR_W-1:0]    rx_dest_i,
  input logic [LEN_W-1:0]     rx_len_i,
  input logic [NUM_STATS-1:0] stat_inc_o,
  input logic [LEN_W-1:0]     tx_octets_o,
  input logic [LEN_W-1:0]     rx_octets_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (stat_inc_o == '0 && tx_octets_o == '0 && rx_octets_o == '0));

  // R2
  tx_octets_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_octets_o != '0) |-> stat_inc_o[S_TX_OK]);

  // R3
  addr_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stat_inc_o[S_TX_BC] && stat_inc_o[S_TX_MC]) &&
    !(stat_inc_o[S_RX_BC] && stat_inc_o[S_RX_MC]));

  // R3
  bc_needs_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_inc_o[S_TX_BC] || stat_inc_o[S_TX_MC]) |-> stat_inc_o[S_TX_OK]);

  // R4
  single_coll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_inc_o[S_TX_SCOL] |-> ($past(tx_coll_cnt_i) == COLL_W'(1) && stat_inc_o[S_TX_OK]));

  // R5
  coll_bins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stat_inc_o[S_TX_SCOL], stat_inc_o[S_TX_MCOL]}));

  // R6
  late_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_late_coll_i |=> stat_inc_o[S_TX_LATE]);

  // R7
  abort_not_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_inc_o[S_TX_XSCOL] |-> !stat_inc_o[S_TX_OK]);

  // R8
  crs_needs_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_inc_o[S_TX_CRS] |-> stat_inc_o[S_TX_OK]);

  // R11
  lost_not_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_inc_o[S_RX_LOST] |-> (!stat_inc_o[S_RX_OK] && rx_octets_o == '0));

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_done_i && !rx_done_i) |=> (stat_inc_o[S_TX_OK] == 1'b0 && stat_inc_o[S_RX_OK] == 1'b0
                                    && stat_inc_o[S_RX_LOST] == 1'b0 && tx_octets_o == '0));
endmodule

bind stat_evt_classifier stat_evt_checker #(
  .ADDR_W(ADDR_W), .COLL_W(COLL_W), .LEN_W(LEN_W), .MAX_COLL(MAX_COLL)
) chk_i (.*);

// File: tb/stat_evt_classifier_tb_top.sv
module stat_evt_classifier_tb_top;
  import stat_evt_pkg::*;
  localparam int ADDR_W = 48;
  localparam int COLL_W = 5;
  localparam int LEN_W  = 16;
  localparam logic [ADDR_W-1:0] BC  = '1;
  localparam logic [ADDR_W-1:0] MC  = 48'h0100_5E00_0001;
  localparam logic [ADDR_W-1:0] UC  = 48'h0012_3456_789A;
  localparam logic [ADDR_W-1:0] UC2 = 48'hFEFF_FFFF_FFFF;  // group bit clear, not all ones

  logic clk = 0, rst_ni = 0;
  logic tx_done, tx_ok, tx_xs, tx_late, tx_def, tx_xdef, tx_crs;
  logic [COLL_W-1:0] tx_coll;
  logic [ADDR_W-1:0] tx_dest, rx_dest;
  logic [LEN_W-1:0] tx_len, rx_len;
  logic rx_done, rx_ok, rx_ovr;
  logic [NUM_STATS-1:0] stat_inc;
  logic [LEN_W-1:0] tx_oct, rx_oct;

  int checks = 0, errors = 0;
  typedef struct packed {
    logic [NUM_STATS-1:0] s;
    logic [LEN_W-1:0] t;
    logic [LEN_W-1:0] r;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  bit    done_flag = 0;

  always #2.5 clk = ~clk;

  stat_evt_classifier dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_done_i(tx_done), .tx_ok_i(tx_ok), .tx_xscol_abort_i(tx_xs),
    .tx_coll_cnt_i(tx_coll), .tx_late_coll_i(tx_late), .tx_deferred_i(tx_def),
    .tx_excess_defer_i(tx_xdef), .tx_carrier_lost_i(tx_crs),
    .tx_dest_i(tx_dest), .tx_len_i(tx_len),
    .rx_done_i(rx_done), .rx_ok_i(rx_ok), .rx_overrun_i(rx_ovr),
    .rx_dest_i(rx_dest), .rx_len_i(rx_len),
    .stat_inc_o(stat_inc), .tx_octets_o(tx_oct), .rx_octets_o(rx_oct)
  );

  task automatic clear();
    tx_done = 0; tx_ok = 0; tx_xs = 0; tx_late = 0; tx_def = 0; tx_xdef = 0; tx_crs = 0;
    tx_coll = '0; tx_dest = UC; tx_len = '0;
    rx_done = 0; rx_ok = 0; rx_ovr = 0; rx_dest = UC; rx_len = '0;
  endtask

  function automatic int kind(logic [ADDR_W-1:0] a);
    if (a == BC) return 2;
    if (a[40]) return 1;
    return 0;
  endfunction

  // expected values from the requirement text
  task automatic push(string tag);
    exp_t e;
    bit tok, rok;
    e = '0;
    tok = tx_done && tx_ok;
    rok = rx_done && rx_ok && !rx_ovr;
    e.s[S_TX_OK]     = tok;
    e.s[S_TX_BC]     = tok && kind(tx_dest) == 2;
    e.s[S_TX_MC]     = tok && kind(tx_dest) == 1;
    e.s[S_TX_DEFER]  = tx_done && tx_def;
    e.s[S_TX_XDEFER] = tx_done && tx_xdef;
    e.s[S_TX_SCOL]   = tok && tx_coll == 1;
    e.s[S_TX_MCOL]   = tok && tx_coll >= 2 && tx_coll <= 15;
    e.s[S_TX_LATE]   = tx_late;
    e.s[S_TX_XSCOL]  = tx_done && !tx_ok && tx_xs;
    e.s[S_TX_CRS]    = tok && tx_crs;
    e.s[S_RX_OK]     = rok;
    e.s[S_RX_BC]     = rok && kind(rx_dest) == 2;
    e.s[S_RX_MC]     = rok && kind(rx_dest) == 1;
    e.s[S_RX_LOST]   = rx_done && rx_ovr;
    e.t = tok ? tx_len : '0;
    e.r = rok ? rx_len : '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic step(string tag);
    push(tag);
    @(negedge clk);
    clear();
  endtask

  // monitor: compares after the edge that registered the pushed item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        string tg;
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if ({stat_inc, tx_oct, rx_oct} !== e) begin
          errors++;
          $display("FAIL %s: stat=%h tx=%0d rx=%0d expected stat=%h tx=%0d rx=%0d",
                   tg, stat_inc, tx_oct, rx_oct, e.s, e.t, e.r);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear();
    tx_done = 1; tx_ok = 1; tx_len = 16'd64; tx_late = 1;  // driven during reset
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (stat_inc !== '0 || tx_oct !== '0 || rx_oct !== '0) begin
      errors++;
      $display("FAIL R1 reset: stat=%h expected 0", stat_inc);
    end
    @(negedge clk);
    rst_ni = 1;
    clear();

    // R1 R2 plain unicast OK frame, then idle
    tx_done = 1; tx_ok = 1; tx_len = 16'd100; step("R1 R2 unicast tx ok");
    step("R1 idle returns zero");
    // R2 R8 carrier loss still OK
    tx_done = 1; tx_ok = 1; tx_crs = 1; tx_len = 16'd1500; step("R2 R8 carrier lost ok");
    // R3 broadcast / multicast / near-broadcast unicast
    tx_done = 1; tx_ok = 1; tx_dest = BC; tx_len = 16'd60; step("R3 tx broadcast");
    tx_done = 1; tx_ok = 1; tx_dest = MC; tx_len = 16'd61; step("R3 tx multicast");
    tx_done = 1; tx_ok = 1; tx_dest = UC2; tx_len = 16'd62; step("R3 tx near-bcast unicast");
    rx_done = 1; rx_ok = 1; rx_dest = BC; rx_len = 16'd70; step("R3 R10 rx broadcast");
    rx_done = 1; rx_ok = 1; rx_dest = MC; rx_len = 16'd71; step("R3 rx multicast");
    rx_done = 1; rx_ok = 0; rx_dest = BC; rx_len = 16'd72; step("R3 R10 rx bad bcast");
    // R4 R5 collision bins at their edges
    tx_done = 1; tx_ok = 1; tx_coll = 5'd0; tx_len = 16'd80; step("R4 zero collisions");
    tx_done = 1; tx_ok = 1; tx_coll = 5'd1; tx_len = 16'd81; step("R4 single collision");
    tx_done = 1; tx_ok = 1; tx_coll = 5'd2; tx_len = 16'd82; step("R5 two collisions");
    tx_done = 1; tx_ok = 1; tx_coll = 5'd15; tx_len = 16'd83; step("R5 fifteen collisions");
    tx_done = 1; tx_ok = 1; tx_coll = 5'd16; tx_len = 16'd84; step("R5 sixteen out of bin");
    tx_done = 1; tx_ok = 0; tx_coll = 5'd1; tx_dest = BC; tx_len = 16'd85; step("R4 R2 failed frame");
    // R6 late collisions: three occurrences for one frame, then completion with one
    tx_late = 1; step("R6 late occurrence a");
    tx_late = 1; step("R6 late occurrence b");
    tx_late = 1; tx_done = 1; tx_ok = 1; tx_coll = 5'd3; tx_len = 16'd90; step("R6 R5 late with frame");
    // R7 abort
    tx_done = 1; tx_ok = 0; tx_xs = 1; tx_coll = 5'd16; tx_dest = MC; tx_len = 16'd91;
    step("R7 excessive collision abort");
    // R9 deferral regardless of status
    tx_done = 1; tx_ok = 1; tx_def = 1; tx_len = 16'd92; step("R9 deferred ok");
    tx_done = 1; tx_ok = 0; tx_xdef = 1; tx_def = 1; step("R9 excessive deferral failed");
    // R10 R11 receive ok and overrun
    rx_done = 1; rx_ok = 1; rx_dest = UC; rx_len = 16'd200; step("R10 rx unicast ok");
    rx_done = 1; rx_ovr = 1; rx_dest = BC; rx_len = 16'd201; step("R11 rx overrun lost");
    // combined tx and rx in one cycle
    tx_done = 1; tx_ok = 1; tx_dest = BC; tx_len = 16'd300;
    rx_done = 1; rx_ok = 1; rx_dest = MC; rx_len = 16'd301; step("R2 R10 both directions");
    // R12 status without completion strobes is ignored
    tx_ok = 1; tx_xs = 0; tx_def = 1; tx_xdef = 1; tx_crs = 1; tx_coll = 5'd1; tx_dest = BC;
    tx_len = 16'd400; rx_ok = 1; rx_ovr = 0; rx_dest = BC; rx_len = 16'd401;
    step("R12 ok fields without done");
    rx_ovr = 1; tx_xs = 1; step("R12 abort and overrun without done");
    step("R12 trailing idle");

    @(negedge clk);
    @(negedge clk);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule